// File: doc/BRIEF.md
# Power-Pulsed Front-End Cycle Controller

This controller sits on the detector-interface side of a chain of front-end readout chips and runs their periodic power cycle. A free-running period counter marks the start of each cycle. At that point a phase machine powers the chips up and keeps external triggers vetoed while the chips wake up. Before opening acquisition it issues a chip reset and then a start-acquisition strobe, always in that order. When the on-time expires it asks for readout and waits for the readout to finish.

Three power domains (analog, converter and digital) each have a pulse-mask bit. A domain set to pulse follows the power window. A domain that is not pulsed stays on whenever the block is out of reset. The digital domain also stays on through readout. Period, on-time and wake-up delay are counted in system clocks. At 125 MHz the nominal 10 ms / 2 ms cycle is 1,250,000 / 250,000 clocks, a 100 µs wake-up is 12,500 clocks, and the low-duty 1 ms / 199 ms cycle (period 25,000,000) also fits the counter.

The phase machine has seven states. IDLE starts a cycle at counter zero (go). WAKE ends when the counter reaches the effective wake value (settled). CRST lasts one cycle (reset_done). CSTART lasts one cycle (armed). ACQ ends when the counter reaches the on-time (on_expired). RDSTART lasts one cycle (requested). RDWAIT returns to IDLE on end-of-readout (drained).

Top module: `ppc_cycle_ctrl`

## Requirements
- R1: While `rst` is high, all three power outputs are 0, `trig_veto` is 1, `trig_out`, `acq_en` and all strobes are 0, whatever the mask and the trigger inputs are.
- R2: The period counter is 0 in reset and steps by one on each clock after reset is released. A cycle starts on the clock that leaves counter value 0 with the machine idle. The power window then covers counter values 1 to `cfg_on_time`, and the cycle repeats every `cfg_period` clocks.
- R3: Mask bit 0 is analog, bit 1 is converter and bit 2 is digital. Bit = 1 makes that domain follow the power window. Bit = 0 holds that domain on at all times outside reset.
- R4: From power-on, the trigger veto stays set through the whole wake-up interval. The chip reset is a single-cycle pulse at counter value Weff+1, where Weff is the effective wake value.
- R5: Weff equals `cfg_wake`, but never less than the parameter `MIN_WAKE` (the settling floor). A smaller programmed value is raised to `MIN_WAKE`.
- R6: `start_acq` is a one-cycle pulse at counter value Weff+2, directly after the chip reset. `acq_en` is high from Weff+3 through `cfg_on_time`. At most one of the three strobes is high in any cycle.
- R7: `start_readout` is a one-cycle pulse at counter value `cfg_on_time`+1. When pulsed, the digital domain stays on until the clock that samples `end_readout` high, and the machine is idle after that clock.
- R8: If readout is still pending when the counter passes 0, that cycle is skipped: no power-up happens until the next counter-0 point reached while idle.
- R9: A high `busy` forces `trig_veto` high and `trig_out` low in the same cycle, in any phase.
- R10: `trig_out` equals `ext_trig` AND NOT `trig_veto`. `trig_veto` is low only during acquisition with `busy` low.
- R11: Pulsed analog and converter domains are off during readout and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Cycle period in clocks |
| cfg_on_time | input | CNT_W | Power window length in clocks |
| cfg_wake | input | CNT_W | Programmed wake-up delay in clocks |
| cfg_pulse_mask | input | 3 | Per-domain pulse select (0 analog, 1 converter, 2 digital) |
| ext_trig | input | 1 | External trigger request |
| busy | input | 1 | Downstream busy, forces veto |
| end_readout | input | 1 | Readout of the chain finished |
| pwr_analog | output | 1 | Analog domain enable |
| pwr_conv | output | 1 | Converter domain enable |
| pwr_digital | output | 1 | Digital domain enable |
| acq_en | output | 1 | Acquisition enable |
| chip_reset | output | 1 | Chip reset pulse |
| start_acq | output | 1 | Start-acquisition pulse |
| start_readout | output | 1 | Start-readout pulse |
| trig_veto | output | 1 | Trigger veto |
| trig_out | output | 1 | Gated trigger to the chips |

## Verification
The assertions assume the following about the configuration:
- `cfg_on_time` is at least Weff+3.
- `cfg_period` is larger than `cfg_on_time`+1.
- The configuration is changed only while reset is held.

They also assume that `end_readout` arrives only after the start-readout pulse. The stimulus keeps to these rules: every scenario programs a fresh configuration under reset, and the bench drives `end_readout` for a single cycle, always several clocks after the readout request. The overrun scenario is the one place where `end_readout` arrives after the next counter-0 point.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_CRST,
        PH_CSTART,
        PH_ACQ,
        PH_RDSTART,
        PH_RDWAIT
    } phase_t;

    localparam int NUM_DOM = 3;
    localparam int DOM_ANA = 0;
    localparam int DOM_CNV = 1;
    localparam int DOM_DIG = 2;

endpackage

// File: rtl/ppc_period_timer.sv
module ppc_period_timer #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] pcnt,
    output logic             at_zero
);

    logic [CNT_W-1:0] last_val;

    assign last_val = period - CNT_W'(1);
    assign at_zero  = (pcnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (pcnt >= last_val)
            pcnt <= '0;
        else
            pcnt <= pcnt + CNT_W'(1);
    end

    AST_PCNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pcnt != '0) |-> ($past(pcnt) == pcnt - CNT_W'(1))); // R2

endmodule

// File: rtl/ppc_phase_fsm.sv
module ppc_phase_fsm
    import ppc_pkg::*;
#(
    parameter int          CNT_W    = 26,
    parameter int unsigned MIN_WAKE = 3125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pcnt,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] cfg_on_time,
    input  logic [CNT_W-1:0] cfg_wake,
    input  logic             end_readout,
    output phase_t           phase
);

    localparam logic [CNT_W-1:0] WAKE_FLOOR = CNT_W'(MIN_WAKE);

    logic [CNT_W-1:0] wake_eff;
    phase_t           phase_nx;

    assign wake_eff = (cfg_wake < WAKE_FLOOR) ? WAKE_FLOOR : cfg_wake;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_IDLE;
        else
            phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:    if (at_zero)              phase_nx = PH_WAKE;
            PH_WAKE:    if (pcnt >= wake_eff)     phase_nx = PH_CRST;
            PH_CRST:                              phase_nx = PH_CSTART;
            PH_CSTART:                            phase_nx = PH_ACQ;
            PH_ACQ:     if (pcnt >= cfg_on_time)  phase_nx = PH_RDSTART;
            PH_RDSTART:                           phase_nx = PH_RDWAIT;
            PH_RDWAIT:  if (end_readout)          phase_nx = PH_IDLE;
            default:                              phase_nx = PH_IDLE;
        endcase
    end

    AST_RST_PRECEDES_START: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CSTART) |-> ($past(phase) == PH_CRST)); // R6

    AST_RST_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CRST) |-> (pcnt == wake_eff + CNT_W'(1))); // R5

    AST_CYCLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAKE && $past(phase) == PH_IDLE) |-> (pcnt == CNT_W'(1))); // R8

endmodule

// File: rtl/ppc_out_decode.sv
module ppc_out_decode
    import ppc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  phase_t             phase,
    input  logic [NUM_DOM-1:0] pulse_mask,
    input  logic               busy,
    input  logic               ext_trig,
    output logic [NUM_DOM-1:0] pwr,
    output logic               acq_en,
    output logic               chip_reset,
    output logic               start_acq,
    output logic               start_readout,
    output logic               trig_veto,
    output logic               trig_out
);

    logic               powered;
    logic               reading;
    logic [NUM_DOM-1:0] window;

    always_comb begin
        powered       = 1'b0;
        reading       = 1'b0;
        acq_en        = 1'b0;
        chip_reset    = 1'b0;
        start_acq     = 1'b0;
        start_readout = 1'b0;
        unique case (phase)
            PH_IDLE:    ;
            PH_WAKE:    powered = 1'b1;
            PH_CRST:    begin powered = 1'b1; chip_reset = 1'b1; end
            PH_CSTART:  begin powered = 1'b1; start_acq  = 1'b1; end
            PH_ACQ:     begin powered = 1'b1; acq_en     = 1'b1; end
            PH_RDSTART: begin reading = 1'b1; start_readout = 1'b1; end
            PH_RDWAIT:  reading = 1'b1;
            default:    ;
        endcase
    end

    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            if (d == DOM_DIG) begin : g_dig
                assign window[d] = powered | reading;
            end else begin : g_fe
                assign window[d] = powered;
            end
            assign pwr[d] = ~rst & (window[d] | ~pulse_mask[d]);
        end
    endgenerate

    assign trig_veto = rst | ~acq_en | busy;
    assign trig_out  = ext_trig & ~trig_veto;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chip_reset, start_acq, start_readout})); // R6

endmodule

// File: rtl/ppc_cycle_ctrl.sv
module ppc_cycle_ctrl
    import ppc_pkg::*;
#(
    parameter int          CNT_W    = 26,
    parameter int unsigned MIN_WAKE = 3125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_on_time,
    input  logic [CNT_W-1:0] cfg_wake,
    input  logic [2:0]       cfg_pulse_mask,
    input  logic             ext_trig,
    input  logic             busy,
    input  logic             end_readout,
    output logic             pwr_analog,
    output logic             pwr_conv,
    output logic             pwr_digital,
    output logic             acq_en,
    output logic             chip_reset,
    output logic             start_acq,
    output logic             start_readout,
    output logic             trig_veto,
    output logic             trig_out
);

    logic [CNT_W-1:0]   pcnt;
    logic               at_zero;
    phase_t             phase;
    logic [NUM_DOM-1:0] pwr;

    ppc_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .period  (cfg_period),
        .pcnt    (pcnt),
        .at_zero (at_zero)
    );

    ppc_phase_fsm #(.CNT_W(CNT_W), .MIN_WAKE(MIN_WAKE)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pcnt        (pcnt),
        .at_zero     (at_zero),
        .cfg_on_time (cfg_on_time),
        .cfg_wake    (cfg_wake),
        .end_readout (end_readout),
        .phase       (phase)
    );

    ppc_out_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .phase         (phase),
        .pulse_mask    (cfg_pulse_mask),
        .busy          (busy),
        .ext_trig      (ext_trig),
        .pwr           (pwr),
        .acq_en        (acq_en),
        .chip_reset    (chip_reset),
        .start_acq     (start_acq),
        .start_readout (start_readout),
        .trig_veto     (trig_veto),
        .trig_out      (trig_out)
    );

    assign pwr_analog  = pwr[DOM_ANA];
    assign pwr_conv    = pwr[DOM_CNV];
    assign pwr_digital = pwr[DOM_DIG];

    AST_RESET_THEN_START: assert property (@(posedge clk) disable iff (rst)
        chip_reset |=> start_acq); // R6

    AST_READOUT_POWERED: assert property (@(posedge clk) disable iff (rst)
        start_readout |-> pwr_digital); // R7

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |-> (trig_veto && !trig_out)); // R9

    AST_ACQ_POWERED: assert property (@(posedge clk) disable iff (rst)
        acq_en |-> (pwr_analog && pwr_conv && pwr_digital)); // R3

    AST_FE_OFF_IN_READOUT: assert property (@(posedge clk) disable iff (rst)
        (start_readout && cfg_pulse_mask[DOM_ANA]) |-> !pwr_analog); // R11

endmodule

// File: tb/tb_ppc_cycle_ctrl.sv
module tb_ppc_cycle_ctrl;

    localparam int CNT_W    = 26;
    localparam int MIN_WAKE = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_period = CNT_W'(64);
    logic [CNT_W-1:0] cfg_on_time = CNT_W'(30);
    logic [CNT_W-1:0] cfg_wake = CNT_W'(10);
    logic [2:0]       cfg_pulse_mask = 3'b111;
    logic             ext_trig = 1'b0;
    logic             busy = 1'b0;
    logic             end_readout = 1'b0;
    logic pwr_analog, pwr_conv, pwr_digital, acq_en, chip_reset;
    logic start_acq, start_readout, trig_veto, trig_out;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ppc_cycle_ctrl #(.CNT_W(CNT_W), .MIN_WAKE(MIN_WAKE)) dut (
        .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_on_time(cfg_on_time),
        .cfg_wake(cfg_wake), .cfg_pulse_mask(cfg_pulse_mask), .ext_trig(ext_trig),
        .busy(busy), .end_readout(end_readout), .pwr_analog(pwr_analog),
        .pwr_conv(pwr_conv), .pwr_digital(pwr_digital), .acq_en(acq_en),
        .chip_reset(chip_reset), .start_acq(start_acq), .start_readout(start_readout),
        .trig_veto(trig_veto), .trig_out(trig_out)
    );

    task automatic check(input string scen, input string tag, input string sig,
                         input logic act, input logic exp, input int cyc);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s %s cycle %0d: actual %b expected %b", scen, tag, sig, cyc, act, exp);
        end
    endtask

    // R1: reset state under hostile inputs
    task automatic hold_reset(input string scen);
        rst = 1'b1;
        end_readout = 1'b0;
        busy = 1'b0;
        ext_trig = 1'b1;
        cfg_pulse_mask = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(scen, "R1", "pwr_analog", pwr_analog, 1'b0, 0);
        check(scen, "R1", "pwr_conv", pwr_conv, 1'b0, 0);
        check(scen, "R1", "pwr_digital", pwr_digital, 1'b0, 0);
        check(scen, "R1", "trig_veto", trig_veto, 1'b1, 0);
        check(scen, "R1", "trig_out", trig_out, 1'b0, 0);
        check(scen, "R1", "acq_en", acq_en, 1'b0, 0);
        check(scen, "R1", "strobes", chip_reset | start_acq | start_readout, 1'b0, 0);
    endtask

    task automatic run_case(input string scen, input int per, input int on, input int wk,
                            input logic [2:0] mask, input int end1, input int end2,
                            input int blo, input int bhi, input int trig_mode, input int ncyc);
        int   weff;
        logic live, pend, rofirst, end_prev, idle_b;
        logic e_acq, e_veto;
        hold_reset(scen);
        cfg_period = CNT_W'(per);
        cfg_on_time = CNT_W'(on);
        cfg_wake = CNT_W'(wk);
        cfg_pulse_mask = mask;
        ext_trig = 1'b0;
        weff = (wk < MIN_WAKE) ? MIN_WAKE : wk;
        live = 1'b0;
        pend = 1'b0;
        end_prev = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 1; j <= ncyc; j++) begin
            int pcb, pc;
            @(posedge clk);
            @(negedge clk);
            pcb = (j - 1) % per;
            pc  = j % per;
            idle_b = !live && !pend;
            if (pend && end_prev) pend = 1'b0;
            rofirst = 1'b0;
            if (live && pcb == on) begin live = 1'b0; pend = 1'b1; rofirst = 1'b1; end
            if (idle_b && pcb == 0) live = 1'b1;
            end_readout = (j == end1) || (j == end2);
            end_prev = end_readout;
            busy = (j >= blo) && (j <= bhi);
            ext_trig = (trig_mode == 1) ? 1'b1 : ((j % 3) == 0);
            #1;
            e_acq  = live && pc >= weff + 3;
            e_veto = !e_acq || busy;
            check(scen, "R3/R11", "pwr_analog", pwr_analog, !mask[0] || live, j);
            check(scen, "R3/R11", "pwr_conv", pwr_conv, !mask[1] || live, j);
            check(scen, "R7", "pwr_digital", pwr_digital, !mask[2] || live || pend, j);
            check(scen, "R4", "chip_reset", chip_reset, live && pc == weff + 1, j);
            check(scen, "R6", "start_acq", start_acq, live && pc == weff + 2, j);
            check(scen, "R6", "acq_en", acq_en, e_acq, j);
            check(scen, "R7", "start_readout", start_readout, rofirst, j);
            check(scen, "R9", "trig_veto", trig_veto, e_veto, j);
            check(scen, "R10", "trig_out", trig_out, ext_trig && !e_veto, j);
        end
        end_readout = 1'b0;
        busy = 1'b0;
    endtask

    // R2 R4 R6 R7: two nominal cycles
    task automatic t_basic();
        run_case("basic", 64, 30, 10, 3'b111, 40, 104, -1, -1, 0, 140);
    endtask

    // R5: programmed wake below the floor is raised
    task automatic t_clamp();
        run_case("clamp_R5", 48, 24, 3, 3'b111, 30, 78, -1, -1, 0, 100);
    endtask

    // R3: only the converter domain pulsed
    task automatic t_hold();
        run_case("hold_R3", 48, 24, 10, 3'b010, 30, -1, -1, -1, 0, 60);
    endtask

    // R9 R10: busy inside acquisition with a constant trigger
    task automatic t_busy();
        run_case("busy_R9", 48, 24, 10, 3'b111, 30, -1, 15, 20, 1, 60);
    endtask

    // R8: readout ends after the next counter zero, one cycle skipped
    task automatic t_overrun();
        run_case("overrun_R8", 48, 24, 10, 3'b111, 53, 127, -1, -1, 0, 150);
    endtask

    // R2: long period with a short window
    task automatic t_lowduty();
        run_case("lowduty_R2", 400, 20, 10, 3'b111, 25, 425, -1, -1, 0, 820);
    endtask

    initial begin
        fork
            begin
                t_basic();
                t_clamp();
                t_hold();
                t_busy();
                t_overrun();
                t_lowduty();
            end
            begin
                repeat (50000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog R2: actual hung expected done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule